// File: doc/BRIEF.md
# Per-Hart Interrupt Delivery Controller

This block sits between a wired-interrupt gateway and one hart. From the gateway it receives, for every source, a pending bit, an enable bit and a 32-bit target word. It picks the most urgent source that is pending, enabled and aimed at this hart. It then applies a priority threshold and a delivery enable, and drives the hart's external interrupt line.

Software reaches the block through a 32-byte register window on a simple select/read/write bus. The window holds a delivery enable, a force bit, a threshold, a read-only top-interrupt view and a claim register. A read of the claim register returns the current top interrupt. In the same cycle it pulses a clear request back to the gateway for that source. Software drains the hart by reading claim until the value is zero. A system with several harts uses one instance per hart, each with its own hart index parameter.

Top module: `hart_irq_deliver`

## Requirements
- R1: After reset the delivery enable, force bit and threshold are all 0, and the interrupt line is low.
- R2: Register offsets are: delivery enable 0x00 (bit 0), force 0x04 (bit 0), threshold 0x08 (bits 7:0), top interrupt 0x18 (read only), claim 0x1C (read only). Any other offset reads 0, and writes to it are ignored.
- R3: A source n (1..NSRC, input bit n-1) takes part only when its pending and enable bits are both 1 and bits 31:18 of its target word equal the hart index parameter.
- R4: Among the sources that take part, the one with the smallest priority number (target bits 7:0) wins. A priority field of 0 counts as 1. On equal priority the lower source number wins.
- R5: The top-interrupt value holds the winning source number in bits 25:16 and its effective priority in bits 7:0, with all other bits 0. It is 0 when no source qualifies.
- R6: A nonzero threshold admits only priorities strictly below it. A threshold of 0 admits every priority.
- R7: The interrupt line is high exactly when the delivery enable is 1 and either the top-interrupt value is nonzero or the force bit is 1.
- R8: A claim read returns the top-interrupt value. When that value is nonzero, the clear-pending output pulses in the same cycle and carries the source number. A claim read of 0 produces no pulse.
- R9: A claim read that returns 0 clears the force bit.
- R10: Repeated claim reads, with the gateway dropping each claimed pending bit, return sources in order of urgency and then 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register window access this cycle |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (claim side effect at the clock edge) |
| bus_addr | input | 5 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| src_pend_i | input | NSRC | Pending bits, bit n-1 is source n |
| src_en_i | input | NSRC | Enable bits, bit n-1 is source n |
| src_tgt_i | input | 32*NSRC | Target words, word n-1 is source n |
| ext_irq_o | output | 1 | External interrupt line to the hart |
| clr_pend_o | output | 1 | Clear-pending pulse to the gateway |
| clr_id_o | output | 10 | Source number to clear |

## Verification
The assertions check on every cycle the properties that follow from the current inputs alone. A clear pulse always names a pending, nonzero source. The line never rises without delivery enabled. An admitted priority always sits under a nonzero threshold. A zero claim leaves the force bit low in the next cycle. Only the bench's scenarios can show arbitration order, tie-breaking, the zero-priority rule, the field layout and the full drain sequence. It compares each read against a model of the selection rules, driven by random source patterns and directed corner cases.

// File: rtl/hid_pkg.sv
package hid_pkg;
  localparam int ID_W   = 10;
  localparam int PRIO_W = 8;
  localparam int HIDX_W = 14;
  localparam int WORD_W = 32;

  localparam logic [4:0] OFF_DELIV = 5'h00;
  localparam logic [4:0] OFF_FORCE = 5'h04;
  localparam logic [4:0] OFF_THRSH = 5'h08;
  localparam logic [4:0] OFF_TOPI  = 5'h18;
  localparam logic [4:0] OFF_CLAIM = 5'h1C;

  function automatic logic [WORD_W-1:0] pack_topi(input logic [ID_W-1:0] id,
                                                  input logic [PRIO_W-1:0] prio);
    return {6'b0, id, 8'b0, prio};
  endfunction
endpackage

// File: rtl/hid_select.sv
module hid_select
  import hid_pkg::*;
#(
  parameter int NSRC    = 8,
  parameter int HART_ID = 3
) (
  input  logic [NSRC-1:0]        pend_i,
  input  logic [NSRC-1:0]        en_i,
  input  logic [NSRC*WORD_W-1:0] tgt_i,
  input  logic [PRIO_W-1:0]      thresh_i,
  output logic                   top_valid_o,
  output logic [ID_W-1:0]        top_id_o,
  output logic [PRIO_W-1:0]      top_prio_o
);
  localparam logic [HIDX_W-1:0] MY_HIDX = HIDX_W'(HART_ID);

  logic [NSRC-1:0]   elig;
  logic [PRIO_W-1:0] eff_prio [NSRC];
  logic              best_v;
  logic [ID_W-1:0]   best_id;
  logic [PRIO_W-1:0] best_p;
  logic              unused_tgt_bits;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_src
      logic [WORD_W-1:0] word;
      assign word        = tgt_i[g*WORD_W +: WORD_W];
      assign elig[g]     = pend_i[g] & en_i[g] & (word[31:18] == MY_HIDX);
      assign eff_prio[g] = (word[PRIO_W-1:0] == '0) ? PRIO_W'(1) : word[PRIO_W-1:0];
    end
  endgenerate

  always_comb begin
    best_v  = 1'b0;
    best_id = '0;
    best_p  = '1;
    for (int k = 0; k < NSRC; k++) begin
      if (elig[k] && (!best_v || eff_prio[k] < best_p)) begin
        best_v  = 1'b1;
        best_id = ID_W'(k + 1);
        best_p  = eff_prio[k];
      end
    end
  end

  assign top_valid_o = best_v & ((thresh_i == '0) | (best_p < thresh_i));
  assign top_id_o    = best_id;
  assign top_prio_o  = best_p;

  always_comb begin
    unused_tgt_bits = 1'b0;
    for (int k = 0; k < NSRC; k++)
      unused_tgt_bits = unused_tgt_bits ^ (^tgt_i[k*WORD_W+8 +: 10]);
  end
endmodule

// File: rtl/hid_regs.sv
module hid_regs
  import hid_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [4:0]        bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] topi_i,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              deliv_en_o,
  output logic              force_o,
  output logic [PRIO_W-1:0] thresh_o,
  output logic              claim_hit_o
);
  logic              deliv_q, deliv_d;
  logic              force_q, force_d;
  logic [PRIO_W-1:0] thr_q, thr_d;
  logic              wr_en;
  logic              unused_wdata;

  assign wr_en       = bus_sel & bus_wr;
  assign claim_hit_o = bus_sel & bus_rd & (bus_addr == OFF_CLAIM);

  always_comb begin
    deliv_d = deliv_q;
    force_d = force_q;
    thr_d   = thr_q;
    if (wr_en && bus_addr == OFF_DELIV) deliv_d = bus_wdata[0];
    if (wr_en && bus_addr == OFF_THRSH) thr_d   = bus_wdata[PRIO_W-1:0];
    if (wr_en && bus_addr == OFF_FORCE)      force_d = bus_wdata[0];
    else if (claim_hit_o && topi_i == '0)    force_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deliv_q <= 1'b0;
      force_q <= 1'b0;
      thr_q   <= '0;
    end else begin
      deliv_q <= deliv_d;
      force_q <= force_d;
      thr_q   <= thr_d;
    end
  end

  always_comb begin
    case (bus_addr)
      OFF_DELIV: bus_rdata = {31'b0, deliv_q};
      OFF_FORCE: bus_rdata = {31'b0, force_q};
      OFF_THRSH: bus_rdata = {24'b0, thr_q};
      OFF_TOPI,
      OFF_CLAIM: bus_rdata = topi_i;
      default:   bus_rdata = '0;
    endcase
  end

  assign deliv_en_o   = deliv_q;
  assign force_o      = force_q;
  assign thresh_o     = thr_q;
  assign unused_wdata = ^bus_wdata[WORD_W-1:PRIO_W];

  AST_ZERO_CLAIM_DROPS_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_hit_o && topi_i == '0 && !(wr_en && bus_addr == OFF_FORCE)) |=> !force_q); // R9
endmodule

// File: rtl/hart_irq_deliver.sv
module hart_irq_deliver
  import hid_pkg::*;
#(
  parameter int NSRC    = 8,
  parameter int HART_ID = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_sel,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [4:0]             bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  input  logic [NSRC-1:0]        src_pend_i,
  input  logic [NSRC-1:0]        src_en_i,
  input  logic [NSRC*32-1:0]     src_tgt_i,
  output logic                   ext_irq_o,
  output logic                   clr_pend_o,
  output logic [ID_W-1:0]        clr_id_o
);
  logic              top_valid;
  logic [ID_W-1:0]   top_id;
  logic [PRIO_W-1:0] top_prio;
  logic [PRIO_W-1:0] thresh;
  logic              deliv_en, force_bit, claim_hit;
  logic [WORD_W-1:0] topi;

  hid_select #(.NSRC(NSRC), .HART_ID(HART_ID)) i_select (
    .pend_i(src_pend_i), .en_i(src_en_i), .tgt_i(src_tgt_i), .thresh_i(thresh),
    .top_valid_o(top_valid), .top_id_o(top_id), .top_prio_o(top_prio)
  );

  assign topi = top_valid ? pack_topi(top_id, top_prio) : '0;

  hid_regs i_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .topi_i(topi), .bus_rdata(bus_rdata),
    .deliv_en_o(deliv_en), .force_o(force_bit), .thresh_o(thresh), .claim_hit_o(claim_hit)
  );

  assign ext_irq_o  = deliv_en & (top_valid | force_bit);
  assign clr_pend_o = claim_hit & top_valid;
  assign clr_id_o   = top_id;

  AST_IRQ_NEEDS_DELIVERY: assert property (@(posedge clk) disable iff (!rst_n)
    ext_irq_o |-> deliv_en); // R7
  AST_CLEAR_NAMES_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pend_o |-> (clr_id_o != '0 && clr_id_o <= ID_W'(NSRC) && src_pend_i[clr_id_o - 1'b1])); // R8
  AST_ADMIT_BELOW_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (top_valid && thresh != '0) |-> (top_prio < thresh)); // R6
  AST_PRIO_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    top_valid |-> (top_prio != '0)); // R4
endmodule

// File: tb/test_hart_irq_deliver.sv
module test_hart_irq_deliver;
  localparam int PERIOD = 10;
  localparam int NSRC   = 8;
  localparam int HART   = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0, bus_rd = 0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NSRC-1:0] pend = '0, en = '0;
  logic [31:0] tgt [NSRC];
  logic [NSRC*32-1:0] tgt_flat;
  logic ext_irq, clr_pend;
  logic [9:0] clr_id;
  int total = 0, bad = 0;
  logic m_deliv = 0, m_force = 0;
  logic [7:0] m_thr = 0;

  always #(PERIOD/2) clk = ~clk;
  always_comb for (int i = 0; i < NSRC; i++) tgt_flat[i*32 +: 32] = tgt[i];

  hart_irq_deliver #(.NSRC(NSRC), .HART_ID(HART)) i_hart_irq_deliver (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_pend_i(pend), .src_en_i(en), .src_tgt_i(tgt_flat),
    .ext_irq_o(ext_irq), .clr_pend_o(clr_pend), .clr_id_o(clr_id)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_topi();
    logic found = 0; int bid = 0; logic [7:0] bp = 8'hFF;
    for (int k = 0; k < NSRC; k++) begin
      logic [7:0] p;
      p = (tgt[k][7:0] == 0) ? 8'd1 : tgt[k][7:0];
      if (pend[k] && en[k] && tgt[k][31:18] == 14'(HART) && (!found || p < bp)) begin
        found = 1; bid = k + 1; bp = p;
      end
    end
    if (!found || (m_thr != 0 && bp >= m_thr)) return 32'h0;
    return {6'b0, 10'(bid), 8'b0, bp};
  endfunction

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    if (a == 5'h00) m_deliv = d[0];
    if (a == 5'h04) m_force = d[0];
    if (a == 5'h08) m_thr = d[7:0];
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d, output logic c, output logic [9:0] id);
    @(negedge clk);
    bus_sel = 1; bus_rd = 1; bus_addr = a;
    #1; d = bus_rdata; c = clr_pend; id = clr_id;
    @(negedge clk);
    bus_sel = 0; bus_rd = 0;
    if (a == 5'h1C && d == 0) m_force = 0;
    if (a == 5'h1C && c) pend[id-1] = 1'b0;
  endtask

  function automatic logic [31:0] mk_tgt(input int h, input int p);
    return {14'(h), 10'b0, 8'(p)};
  endfunction

  initial begin
    #(PERIOD*150000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d, exp; logic c; logic [9:0] id;
    void'($urandom(32'h5EED));
    for (int i = 0; i < NSRC; i++) tgt[i] = '0;
    #(PERIOD*3); @(negedge clk); rst_n = 1;
    // R1 reset values
    rd(5'h00, d, c, id); check("R1 deliv", d, 0);
    rd(5'h04, d, c, id); check("R1 force", d, 0);
    rd(5'h08, d, c, id); check("R1 thresh", d, 0);
    check("R1 irq", {31'b0, ext_irq}, 0);
    // R2 readback and unmapped offset
    wr(5'h08, 32'hFFFF_FF05); rd(5'h08, d, c, id); check("R2 thresh field", d, 32'h05);
    wr(5'h10, 32'hFFFF_FFFF); rd(5'h10, d, c, id); check("R2 unmapped", d, 0);
    wr(5'h08, 0); wr(5'h00, 1); rd(5'h00, d, c, id); check("R2 deliv", d, 1);
    // R3 other hart / disabled ignored
    tgt[0] = mk_tgt(HART + 1, 2); pend[0] = 1; en[0] = 1;
    tgt[1] = mk_tgt(HART, 2);     pend[1] = 1; en[1] = 0;
    #1; rd(5'h18, d, c, id); check("R3 not eligible", d, 0);
    check("R3 irq low", {31'b0, ext_irq}, 0);
    // R4 tie and zero priority
    en[1] = 1; tgt[2] = mk_tgt(HART, 0); pend[2] = 1; en[2] = 1;
    tgt[4] = mk_tgt(HART, 1); pend[4] = 1; en[4] = 1;
    rd(5'h18, d, c, id); check("R4 R5 zero-prio tie", d, {6'b0, 10'd3, 8'b0, 8'd1});
    check("R7 irq high", {31'b0, ext_irq}, 1);
    // R6 threshold boundary
    wr(5'h08, 1); rd(5'h18, d, c, id); check("R6 equal masked", d, 0);
    wr(5'h08, 2); rd(5'h18, d, c, id); check("R6 below admitted", d, {6'b0, 10'd3, 8'b0, 8'd1});
    wr(5'h08, 0);
    // R8 R10 drain: prios src3=1,src5=1,src2=2 -> 3,5,2,0
    rd(5'h1C, d, c, id); check("R8 claim1", d, {6'b0, 10'd3, 8'b0, 8'd1});
    check("R8 clear pulse", {21'b0, c, id}, {21'b0, 1'b1, 10'd3});
    rd(5'h1C, d, c, id); check("R10 claim2", d, {6'b0, 10'd5, 8'b0, 8'd1});
    rd(5'h1C, d, c, id); check("R10 claim3", d, {6'b0, 10'd2, 8'b0, 8'd2});
    rd(5'h1C, d, c, id); check("R10 drained", d, 0);
    check("R8 no pulse on zero", {31'b0, c}, 0);
    // R7 R9 force
    wr(5'h04, 1); check("R7 force irq", {31'b0, ext_irq}, 1);
    wr(5'h00, 0); check("R7 no delivery", {31'b0, ext_irq}, 0);
    wr(5'h00, 1);
    rd(5'h1C, d, c, id); rd(5'h04, d, c, id); check("R9 force cleared", d, 0);
    check("R9 irq low", {31'b0, ext_irq}, 0);
    // random
    for (int it = 0; it < 300; it++) begin
      for (int k = 0; k < NSRC; k++)
        tgt[k] = mk_tgt(($urandom % 3 != 0) ? HART : ($urandom % 16384), $urandom % 6);
      pend = NSRC'($urandom); en = NSRC'($urandom);
      if (it % 4 == 0) wr(5'h08, $urandom % 7);
      if (it % 9 == 0) wr(5'h00, $urandom % 2);
      #1; exp = model_topi();
      rd(5'h18, d, c, id); check("R3 R4 R6 random topi", d, exp);
      check("R7 random irq", {31'b0, ext_irq}, {31'b0, m_deliv & (exp != 0 | m_force)});
      if (it % 3 == 0) begin
        exp = model_topi();
        rd(5'h1C, d, c, id); check("R8 random claim", d, exp);
        check("R8 random pulse", {31'b0, c}, {31'b0, exp != 0});
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule